// File: doc/BRIEF.md
# Cross-domain register write synchronizer

This block carries writes to four control fields from a bus-clock register interface into a separately clocked peripheral core. The four controls are a software reset, an enable, a FIFO-clear operation and a length value. Each control has its own toggle handshake. A request toggle is passed into the core domain through a two-flop synchronizer. The core answers with an acknowledge toggle, which returns through a second two-flop synchronizer. A control's busy flag is high while its request and acknowledge toggles differ.

Software polls a read-only 32-bit busy word to learn when a write has landed in the core domain. A length write that arrives while the previous length write is still in flight is refused and raises a one-cycle bus error. The core clock may stop, as it does in client operation where it only runs during a transfer. While it is stopped, any busy flag that is pending stays set.

A software reset has priority over the other controls. Once it completes, the enable and length values are zero in both domains and no busy flag is left set.

Top module: `xdom_wrsync`

## Requirements
- R1: After reset `busy_word` is zero, `bus_err` is low, and `core_enable` and `core_length` are zero. Bit 3 and bits 31..5 of `busy_word` are always zero.
- R2: An accepted software-reset write sets `busy_word[0]` on the next bus cycle. The bit stays set until the core domain has taken the reset. `core_swrst` pulses for exactly one core cycle per accepted write.
- R3: When the software reset completes, `core_enable` and `core_length` are zero and `busy_word` is all zero. The bus-side enable state is cleared, so a later FIFO-clear is not synchronized. Enable, FIFO-clear and length writes made while `busy_word[0]` is set are ignored.
- R4: An enable write (value 0 or 1) sets `busy_word[1]` on the next bus cycle. By the time the bit clears, `core_enable` holds the written value.
- R5: A FIFO-clear write while the last written enable value is 1 sets `busy_word[2]` and produces one `core_flush` pulse. While that value is 0, the write leaves `busy_word[2]` clear and produces no pulse.
- R6: A length write sets `busy_word[4]` on the next bus cycle. By the time the bit clears, `core_length` holds the written value.
- R7: A length write while `busy_word[4]` is set drives `bus_err` high for exactly the one bus cycle after the write. The pending length value is not changed. No other write raises `bus_err`.
- R8: While `core_clk` is stopped, a pending `busy_word[4]` stays set and `core_length` keeps its old value. Once the clock resumes, the write completes.
- R9: An enable write while `busy_word[1]` is set is dropped and has no effect on `core_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus interface clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_swrst | input | 1 | Write strobe: request a software reset |
| wr_enable | input | 1 | Write strobe for the enable control |
| wr_enable_val | input | 1 | Enable value written |
| wr_flush | input | 1 | Write strobe: request a FIFO clear |
| wr_length | input | 1 | Write strobe for the length control |
| wr_length_val | input | LEN_W | Length value written |
| busy_word | output | 32 | Busy status: bit0 reset, bit1 enable, bit2 FIFO-clear, bit4 length |
| bus_err | output | 1 | One-cycle error on a length write while length is busy |
| core_clk | input | 1 | Core clock, may be stopped |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| core_swrst | output | 1 | One-cycle software-reset pulse in the core domain |
| core_enable | output | 1 | Enable value in the core domain |
| core_flush | output | 1 | One-cycle FIFO-clear pulse in the core domain |
| core_length | output | LEN_W | Length value in the core domain |

## Verification
The hardest situations to reach from the ports are a length write stranded behind a stopped core clock, and a software reset that races writes already in flight. The bench gates `core_clk` with its own run flag and issues a length write while the clock is frozen. It then holds for hundreds of bus cycles, checks that the busy bit and the old core value persist, and lets the clock run again. For the race, a length write and a software reset are issued on consecutive bus cycles, followed by an enable write while the reset is pending. The bench then checks that everything has collapsed to zero and that a later FIFO-clear is not synchronized.

// File: rtl/xds_pkg.sv
package xds_pkg;

    localparam int NUM_CH = 4;
    localparam int STAT_W = 32;

    // Channel order; the status bit for each is given by stat_pos()
    typedef enum logic [1:0] {
        CH_SWRST  = 2'd0,
        CH_ENABLE = 2'd1,
        CH_FLUSH  = 2'd2,
        CH_LENGTH = 2'd3
    } ch_e;

    typedef logic [NUM_CH-1:0] ch_vec_t;

    // Bus-side shadow of the values that cross
    typedef struct packed {
        logic       enable;
        logic [7:0] spare;
    } bus_ctl_t;

    function automatic int stat_pos(input int ch);
        case (ch)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input ch_vec_t b);
        logic [STAT_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            w[stat_pos(i)] = b[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/xds_sync2.sv
module xds_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/xds_hs_chan.sv
module xds_hs_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic req_i,
    output logic busy_o,
    output logic done_o,
    input  logic core_clk,
    input  logic core_rst,
    output logic fire_o
);
    logic req_tgl;
    logic ack_tgl;
    logic req_seen;
    logic ack_seen;
    logic busy_q;

    // Bus side: flip the request toggle on an accepted write
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_tgl <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            if (req_i && !busy_o) begin
                req_tgl <= ~req_tgl;
            end
            busy_q <= busy_o;
        end
    end

    xds_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ack_tgl),
        .q   (ack_seen)
    );

    assign busy_o = req_tgl ^ ack_seen;
    assign done_o = busy_q & ~busy_o;

    // Core side: follow the synchronized request, firing once per change
    xds_sync2 #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (core_clk),
        .rst (core_rst),
        .d   (req_tgl),
        .q   (req_seen)
    );

    always_ff @(posedge core_clk) begin
        if (core_rst) begin
            ack_tgl <= 1'b0;
        end else begin
            ack_tgl <= req_seen;
        end
    end

    assign fire_o = req_seen ^ ack_tgl;

    // R6: an accepted write makes the channel busy on the next bus cycle
    assert_accept_busy_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (req_i && !busy_o) |=> busy_o);

    // R9: an idle channel with no write stays idle
    assert_idle_stays_R9: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (!req_i && !busy_o) |=> !busy_o);

    // R2: each crossing fires for a single core cycle
    assert_fire_single_R2: assert property (@(posedge core_clk) disable iff (core_rst)
        fire_o |=> !fire_o);
endmodule

// File: rtl/xds_core_regs.sv
module xds_core_regs
    import xds_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             core_clk,
    input  logic             core_rst,
    input  ch_vec_t          fire_i,
    input  logic             en_hold_i,
    input  logic [LEN_W-1:0] len_hold_i,
    output logic             core_en_o,
    output logic [LEN_W-1:0] core_len_o
);
    // Reset wins over any update arriving in the same core cycle
    always_ff @(posedge core_clk) begin
        if (core_rst) begin
            core_en_o  <= 1'b0;
            core_len_o <= '0;
        end else if (fire_i[CH_SWRST]) begin
            core_en_o  <= 1'b0;
            core_len_o <= '0;
        end else begin
            if (fire_i[CH_ENABLE]) begin
                core_en_o <= en_hold_i;
            end
            if (fire_i[CH_LENGTH]) begin
                core_len_o <= len_hold_i;
            end
        end
    end

    assert_swrst_clears_core_R3: assert property (@(posedge core_clk) disable iff (core_rst)
        fire_i[CH_SWRST] |=> (!core_en_o && core_len_o == '0));

    assert_len_applied_R6: assert property (@(posedge core_clk) disable iff (core_rst)
        (fire_i[CH_LENGTH] && !fire_i[CH_SWRST]) |=> (core_len_o == $past(len_hold_i)));

    assert_en_applied_R4: assert property (@(posedge core_clk) disable iff (core_rst)
        (fire_i[CH_ENABLE] && !fire_i[CH_SWRST]) |=> (core_en_o == $past(en_hold_i)));
endmodule

// File: rtl/xdom_wrsync.sv
module xdom_wrsync
    import xds_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              wr_swrst,
    input  logic              wr_enable,
    input  logic              wr_enable_val,
    input  logic              wr_flush,
    input  logic              wr_length,
    input  logic [LEN_W-1:0]  wr_length_val,
    output logic [STAT_W-1:0] busy_word,
    output logic              bus_err,
    input  logic              core_clk,
    input  logic              core_rst,
    output logic              core_swrst,
    output logic              core_enable,
    output logic              core_flush,
    output logic [LEN_W-1:0]  core_length
);
    ch_vec_t          busy;
    ch_vec_t          done;
    ch_vec_t          accept;
    ch_vec_t          fire;
    logic             en_hold;
    logic [LEN_W-1:0] len_hold;
    logic             sw_free;

    assign sw_free = !busy[CH_SWRST];

    // Write acceptance: a pending reset blocks every other control
    always_comb begin
        accept[CH_SWRST]  = wr_swrst  && sw_free;
        accept[CH_ENABLE] = wr_enable && sw_free && !busy[CH_ENABLE];
        accept[CH_FLUSH]  = wr_flush  && sw_free && !busy[CH_FLUSH] && en_hold;
        accept[CH_LENGTH] = wr_length && sw_free && !busy[CH_LENGTH];
    end

    // Bus-side held values; these stay stable while their channel is busy
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            en_hold  <= 1'b0;
            len_hold <= '0;
            bus_err  <= 1'b0;
        end else begin
            if (done[CH_SWRST]) begin
                en_hold  <= 1'b0;
                len_hold <= '0;
            end
            if (accept[CH_ENABLE]) begin
                en_hold <= wr_enable_val;
            end
            if (accept[CH_LENGTH]) begin
                len_hold <= wr_length_val;
            end
            bus_err <= wr_length && busy[CH_LENGTH];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        xds_hs_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .bus_clk  (bus_clk),
            .bus_rst  (bus_rst),
            .req_i    (accept[g]),
            .busy_o   (busy[g]),
            .done_o   (done[g]),
            .core_clk (core_clk),
            .core_rst (core_rst),
            .fire_o   (fire[g])
        );
    end

    xds_core_regs #(.LEN_W(LEN_W)) u_core (
        .core_clk   (core_clk),
        .core_rst   (core_rst),
        .fire_i     (fire),
        .en_hold_i  (en_hold),
        .len_hold_i (len_hold),
        .core_en_o  (core_enable),
        .core_len_o (core_length)
    );

    assign core_swrst = fire[CH_SWRST];
    assign core_flush = fire[CH_FLUSH];
    assign busy_word  = pack_status(busy);

    assert_err_source_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        bus_err |-> $past(wr_length && busy[CH_LENGTH]));

    assert_len_hold_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (busy[CH_LENGTH] && $past(busy[CH_LENGTH])) |-> $stable(len_hold));

    assert_flush_gated_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_flush && !en_hold && !busy[CH_FLUSH]) |=> !busy[CH_FLUSH]);

    assert_swrst_clears_R3: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $fell(busy[CH_SWRST]) |-> (busy == '0));
endmodule

// File: tb/xdom_wrsync_tb.sv
`timescale 1ns/1ps
module xdom_wrsync_tb_top;
    localparam int LEN_W = 8;

    typedef struct packed {
        logic [1:0] op;     // 1 enable, 2 flush, 3 length
        logic [7:0] val;
        logic       exp_busy;
        logic       exp_en;
        logic [7:0] exp_len;
        logic       exp_flush;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h01, 1'b1, 1'b1, 8'h00, 1'b0},
        '{2'd3, 8'h2A, 1'b1, 1'b1, 8'h2A, 1'b0},
        '{2'd2, 8'h00, 1'b1, 1'b1, 8'h2A, 1'b1},
        '{2'd3, 8'h15, 1'b1, 1'b1, 8'h15, 1'b0},
        '{2'd1, 8'h00, 1'b1, 1'b0, 8'h15, 1'b0},
        '{2'd2, 8'h00, 1'b0, 1'b0, 8'h15, 1'b0},
        '{2'd1, 8'h01, 1'b1, 1'b1, 8'h15, 1'b0},
        '{2'd3, 8'hFF, 1'b1, 1'b1, 8'hFF, 1'b0},
        '{2'd2, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1}
    };

    logic             bus_clk = 1'b0;
    logic             core_clk = 1'b0;
    logic             core_run = 1'b1;
    logic             bus_rst = 1'b1;
    logic             core_rst = 1'b1;
    logic             wr_swrst = 1'b0;
    logic             wr_enable = 1'b0;
    logic             wr_enable_val = 1'b0;
    logic             wr_flush = 1'b0;
    logic             wr_length = 1'b0;
    logic [LEN_W-1:0] wr_length_val = '0;
    logic [31:0]      busy_word;
    logic             bus_err;
    logic             core_swrst;
    logic             core_enable;
    logic             core_flush;
    logic [LEN_W-1:0] core_length;

    int n_tests = 0;
    int n_fail  = 0;
    int flush_cnt = 0;
    int sw_cnt = 0;
    bit unimpl_bad = 1'b0;

    always #2.5 bus_clk = ~bus_clk;
    always #6.5 if (core_run) core_clk = ~core_clk;

    xdom_wrsync #(.LEN_W(LEN_W)) dut_i (
        .bus_clk(bus_clk), .bus_rst(bus_rst),
        .wr_swrst(wr_swrst), .wr_enable(wr_enable), .wr_enable_val(wr_enable_val),
        .wr_flush(wr_flush), .wr_length(wr_length), .wr_length_val(wr_length_val),
        .busy_word(busy_word), .bus_err(bus_err),
        .core_clk(core_clk), .core_rst(core_rst),
        .core_swrst(core_swrst), .core_enable(core_enable),
        .core_flush(core_flush), .core_length(core_length)
    );

    always @(posedge core_clk) begin
        if (core_flush) flush_cnt++;
        if (core_swrst) sw_cnt++;
    end

    always @(negedge bus_clk) begin
        if (!bus_rst && (busy_word & ~32'h0000_0017) != 32'h0) unimpl_bad = 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle(input string tag);
        for (int k = 0; k < 400 && busy_word != 32'h0; k++) @(negedge bus_clk);
        chk({tag, " idle"}, busy_word, 32'h0);
    endtask

    task automatic do_op(input logic [1:0] op, input logic [7:0] val);
        @(negedge bus_clk);
        case (op)
            2'd1: begin wr_enable = 1'b1; wr_enable_val = val[0]; end
            2'd2: wr_flush = 1'b1;
            2'd3: begin wr_length = 1'b1; wr_length_val = val; end
            default: wr_swrst = 1'b1;
        endcase
        @(negedge bus_clk);
        wr_enable = 1'b0; wr_flush = 1'b0; wr_length = 1'b0; wr_swrst = 1'b0;
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20) @(negedge bus_clk);
        bus_rst = 1'b0; core_rst = 1'b0;
        @(negedge bus_clk);
        chk("R1 reset busy_word", busy_word, 32'h0);
        chk("R1 reset bus_err", {31'h0, bus_err}, 32'h0);
        chk("R1 reset core_enable", {31'h0, core_enable}, 32'h0);
        chk("R1 reset core_length", {24'h0, core_length}, 32'h0);

        // Table walk: R4 enable, R5 flush, R6 length
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int f0;
            string tag;
            int bitpos;
            v = VECS[i];
            f0 = flush_cnt;
            tag = (v.op == 2'd1) ? "R4" : (v.op == 2'd2) ? "R5" : "R6";
            bitpos = (v.op == 2'd1) ? 1 : (v.op == 2'd2) ? 2 : 4;
            do_op(v.op, v.val);
            chk({tag, " busy rise"}, {31'h0, busy_word[bitpos]}, {31'h0, v.exp_busy});
            wait_idle(tag);
            chk({tag, " core_enable"}, {31'h0, core_enable}, {31'h0, v.exp_en});
            chk({tag, " core_length"}, {24'h0, core_length}, {24'h0, v.exp_len});
            chk("R5 flush pulses", flush_cnt - f0, {31'h0, v.exp_flush});
        end

        // R8: stopped core clock strands the length write
        core_run = 1'b0;
        repeat (10) @(negedge bus_clk);
        do_op(2'd3, 8'h5A);
        chk("R8 busy rise", {31'h0, busy_word[4]}, 32'h1);
        repeat (300) @(negedge bus_clk);
        chk("R8 busy held", {31'h0, busy_word[4]}, 32'h1);
        chk("R8 core_length held", {24'h0, core_length}, 32'hFF);
        core_run = 1'b1;
        wait_idle("R8");
        chk("R8 core_length after resume", {24'h0, core_length}, 32'h5A);

        // R7: length write while length busy
        @(negedge bus_clk);
        wr_length = 1'b1; wr_length_val = 8'h11;
        @(negedge bus_clk);
        wr_length_val = 8'h22;
        chk("R7 no err on first write", {31'h0, bus_err}, 32'h0);
        chk("R7 length busy", {31'h0, busy_word[4]}, 32'h1);
        @(negedge bus_clk);
        wr_length = 1'b0;
        chk("R7 err pulse", {31'h0, bus_err}, 32'h1);
        @(negedge bus_clk);
        chk("R7 err one cycle", {31'h0, bus_err}, 32'h0);
        wait_idle("R7");
        chk("R7 pending kept", {24'h0, core_length}, 32'h11);

        // R9: enable write while enable busy is dropped
        @(negedge bus_clk);
        wr_enable = 1'b1; wr_enable_val = 1'b0;
        @(negedge bus_clk);
        wr_enable_val = 1'b1;
        @(negedge bus_clk);
        wr_enable = 1'b0;
        chk("R7 no err on enable", {31'h0, bus_err}, 32'h0);
        wait_idle("R9");
        chk("R9 core_enable", {31'h0, core_enable}, 32'h0);

        // R2/R3: software reset racing a pending length write
        do_op(2'd1, 8'h01);
        wait_idle("R3 setup");
        begin
            int s0;
            int f0;
            s0 = sw_cnt;
            @(negedge bus_clk);
            wr_length = 1'b1; wr_length_val = 8'h44;
            @(negedge bus_clk);
            wr_length = 1'b0; wr_swrst = 1'b1;
            @(negedge bus_clk);
            wr_swrst = 1'b0;
            chk("R2 swrst busy", {31'h0, busy_word[0]}, 32'h1);
            chk("R6 length busy", {31'h0, busy_word[4]}, 32'h1);
            wr_enable = 1'b1; wr_enable_val = 1'b1;
            @(negedge bus_clk);
            wr_enable = 1'b0;
            chk("R3 enable ignored", {31'h0, busy_word[1]}, 32'h0);
            chk("R2 swrst still busy", {31'h0, busy_word[0]}, 32'h1);
            wait_idle("R3");
            chk("R2 swrst pulses", sw_cnt - s0, 32'h1);
            chk("R3 core_enable", {31'h0, core_enable}, 32'h0);
            chk("R3 core_length", {24'h0, core_length}, 32'h0);
            f0 = flush_cnt;
            do_op(2'd2, 8'h00);
            chk("R3 flush after reset", {31'h0, busy_word[2]}, 32'h0);
            repeat (40) @(negedge bus_clk);
            chk("R3 no flush pulse", flush_cnt - f0, 32'h0);
        end

        chk("R1 unimplemented bits", {31'h0, unimpl_bad}, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule